// File: doc/BRIEF.md
# Banked GPIO Controller with Pin Interrupts

This block drives and samples general-purpose pins in several banks of up to 32 pins each. Software reaches it over a plain strobe bus. Each bank holds eight 32-bit registers:

- the value to drive on each pin;
- the synchronized value read back from each pin;
- a per-pin direction control;
- an interrupt routing mask and an interrupt enable mask;
- a sticky interrupt status word;
- two trigger-selection words.

Every register can be written in four ways through address aliases: replace, set-by-ones, clear-by-ones and toggle-by-ones. Software can therefore change single pins without a read-modify-write sequence.

Pad inputs pass through a two-flop synchronizer. The synchronized values feed a trigger detector per pin. Each pin can be set to trigger on a rising edge, a falling edge, a high level or a low level. Detected events collect in the status word. Each bank raises one interrupt line whenever an enabled status bit is pending. A bank may be built with fewer than 32 pins. The bits above its pin count are absent: they read as zero, ignore writes and never trigger.

Top module: `gpio_banked`

## Requirements
- R1: A register is addressed as reg*0x100 + bank*0x10 + op*4. The register codes are 0 drive value, 1 pin input, 2 direction, 3 routing, 4 enable, 5 status, 6 level-select and 7 polarity. Banks are independent.
- R2: The op field selects how a write applies. Op 0 replaces the register. Op 1 sets the bits written as one. Op 2 clears the bits written as one. Op 3 inverts the bits written as one. Bits written as zero are unchanged under ops 1 to 3.
- R3: A read strobe loads `bus_rdata` at the next clock edge with the base value of the addressed register, whatever the op field. A register code above 7, a bank at or beyond BANKS, or a nonzero `bus_addr[1:0]` reads zero, and a write to such an address does nothing.
- R4: A direction bit of 1 drives `pad_oe` high for that pin. `pad_out` always carries the drive-value register.
- R5: The pin-input register returns the pad value after two clock edges of synchronization, for every implemented pin, whatever its direction. All writes to it are ignored.
- R6: Each pin's trigger code is {polarity bit, level-select bit}: 0 is a falling edge, 1 a low level, 2 a rising edge and 3 a high level.
- R7: An edge trigger sets the status bit when the synchronized input differs from its value one cycle earlier, in the selected direction. The bit stays set until software clears it.
- R8: A level trigger sets the status bit on every cycle the level holds. If the bit is cleared while the level persists, it is zero for one cycle and set again on the next.
- R9: A pin whose routing bit is 0 never sets its status bit from the pad.
- R10: `irq[b]` is high exactly while bank b has a status bit set whose enable bit is also set. A clear enable bit does not stop the status bit from being recorded.
- R11: Writing ones to the status clear alias (code 5, op 2) clears those pending bits, and all ones clears the whole bank. An edge detected in the same cycle as a clear survives it. Without a bus write, a raised `irq` stays raised.
- R12: The pins at and above a bank's pin count read as zero, ignore writes, never drive `pad_out` or `pad_oe`, and never set status. The default counts are 29, 32 and 21.
- R13: After reset every register is zero, `pad_oe` and `pad_out` are low and no `irq` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address: register, bank and op fields |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, data valid after the next edge |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | BANKS*32 | Pad input values, bank b at bits 32*b upward |
| pad_out | output | BANKS*32 | Pad drive values |
| pad_oe | output | BANKS*32 | Pad output enables |
| irq | output | BANKS | One interrupt line per bank |

## Verification
The bench reads the pin-input register one cycle after a pad change and expects the old value, then reads it one cycle later and expects the new one. A synchronizer that is one flop short, or one flop too long, fails one of those two reads.

It clears a persistent low level and checks that `irq` drops for exactly one cycle and then returns. A design that ignores the clear would keep `irq` up, and one that lets the clear stick would leave it down.

It lands an edge in the very cycle of a clear-all write. A design that lets the clear win would lose that event.

The remaining checks cover other ways a design could go wrong:

- The write aliases each touch only the bits written as one.
- A read through an alias address returns the base value; a design that decoded the op field on reads would return something else.
- An unrouted pin stays quiet.
- A pin with its enable bit clear still records status.
- The short banks read back zero in their absent bits, so an unmasked register would show up.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int DATA_W   = 32;
  localparam int NUM_REGS = 8;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLR   = 2'd2,
    OP_TOG   = 2'd3
  } wr_op_e;

  typedef enum int {
    RG_DRIVE = 0,
    RG_INPUT = 1,
    RG_DIR   = 2,
    RG_ROUTE = 3,
    RG_IEN   = 4,
    RG_STAT  = 5,
    RG_LVL   = 6,
    RG_POL   = 7
  } reg_code_e;

  // New register value after a write through one of the four ops.
  function automatic logic [DATA_W-1:0] op_apply(
    input logic [DATA_W-1:0] cur,
    input logic [DATA_W-1:0] wd,
    input wr_op_e            op
  );
    logic [DATA_W-1:0] res;
    case (op)
      OP_WRITE: res = wd;
      OP_SET:   res = cur | wd;
      OP_CLR:   res = cur & ~wd;
      default:  res = cur ^ wd;
    endcase
    return res;
  endfunction

  // Mask of the implemented pins for a bank with n pins.
  function automatic logic [DATA_W-1:0] pin_mask(input int n);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) m[i] = (i < n);
    return m;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stable_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= '0;
      stable_q <= '0;
    end else begin
      meta_q   <= async_in;
      stable_q <= meta_q;
    end
  end

  assign sync_out = stable_q;
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] smp,
  input  logic [W-1:0] route,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] pol,
  output logic [W-1:0] edge_hit,
  output logic [W-1:0] level_hit
);
  logic [W-1:0] prev_q;
  logic [W-1:0] rise;
  logic [W-1:0] fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= smp;
  end

  assign rise      = smp & ~prev_q;
  assign fall      = ~smp & prev_q;
  // Code {pol,lvl}: 0 fall, 1 low, 2 rise, 3 high.
  assign edge_hit  = route & ~lvl & ((pol & rise) | (~pol & fall));
  assign level_hit = route & lvl & ~(smp ^ pol);
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int PINS = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [DATA_W-1:0]          pad_in,
  input  logic [NUM_REGS-1:0]        wr_sel,
  input  wr_op_e                     op,
  input  logic [DATA_W-1:0]          wdata,
  output logic [NUM_REGS*DATA_W-1:0] regs_flat,
  output logic [DATA_W-1:0]          pad_out,
  output logic [DATA_W-1:0]          pad_oe,
  output logic                       irq
);
  localparam logic [DATA_W-1:0] IMPL = pin_mask(PINS);

  logic [DATA_W-1:0] smp;
  logic [DATA_W-1:0] edge_hit;
  logic [DATA_W-1:0] level_hit;
  logic [DATA_W-1:0] route_v, lvl_v, pol_v, ien_v, stat_v;

  gpio_sync #(.W(DATA_W)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pad_in),
    .sync_out (smp)
  );

  gpio_trig_detect #(.W(DATA_W)) u_det (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp       (smp),
    .route     (route_v),
    .lvl       (lvl_v),
    .pol       (pol_v),
    .edge_hit  (edge_hit),
    .level_hit (level_hit)
  );

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    if (r == int'(RG_INPUT)) begin : g_input
      logic unused_wr;
      assign unused_wr = wr_sel[r];
      assign regs_flat[r*DATA_W +: DATA_W] = smp & IMPL;
    end else if (r == int'(RG_STAT)) begin : g_stat
      logic [DATA_W-1:0] q;
      logic [DATA_W-1:0] wr_val;
      logic [DATA_W-1:0] dropped;
      logic [DATA_W-1:0] nxt;
      always_comb begin
        wr_val  = wr_sel[r] ? op_apply(q, wdata, op) : q;
        dropped = q & ~wr_val;
        // Edges survive a clear; a held level waits one cycle.
        nxt     = (wr_val | edge_hit | (level_hit & ~dropped)) & IMPL;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
      end
      assign regs_flat[r*DATA_W +: DATA_W] = q;
    end else begin : g_cfg
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         q <= '0;
        else if (wr_sel[r]) q <= op_apply(q, wdata, op) & IMPL;
      end
      assign regs_flat[r*DATA_W +: DATA_W] = q;
    end
  end

  assign route_v = regs_flat[int'(RG_ROUTE)*DATA_W +: DATA_W];
  assign lvl_v   = regs_flat[int'(RG_LVL)*DATA_W +: DATA_W];
  assign pol_v   = regs_flat[int'(RG_POL)*DATA_W +: DATA_W];
  assign ien_v   = regs_flat[int'(RG_IEN)*DATA_W +: DATA_W];
  assign stat_v  = regs_flat[int'(RG_STAT)*DATA_W +: DATA_W];
  assign pad_out = regs_flat[int'(RG_DRIVE)*DATA_W +: DATA_W];
  assign pad_oe  = regs_flat[int'(RG_DIR)*DATA_W +: DATA_W];
  assign irq     = |(stat_v & ien_v);
endmodule

// File: rtl/gpio_banked.sv
module gpio_banked
  import gpio_bank_pkg::*;
#(
  parameter int                 BANKS      = 3,
  parameter int                 ADDR_W     = 12,
  parameter logic [BANKS*8-1:0] PIN_COUNTS = {8'd21, 8'd32, 8'd29}
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [DATA_W-1:0]       bus_wdata,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  output logic [DATA_W-1:0]       bus_rdata,
  input  logic [BANKS*DATA_W-1:0] pad_in,
  output logic [BANKS*DATA_W-1:0] pad_out,
  output logic [BANKS*DATA_W-1:0] pad_oe,
  output logic [BANKS-1:0]        irq
);
  localparam int RG_W = ADDR_W - 8;
  localparam int BK_W = 4;

  logic [RG_W-1:0]  rg_f;
  logic [BK_W-1:0]  bk_f;
  wr_op_e           op_f;
  logic             addr_ok;
  logic [DATA_W-1:0] rd_mux;

  logic [NUM_REGS-1:0]        wr_sel    [BANKS];
  logic [NUM_REGS*DATA_W-1:0] bank_regs [BANKS];

  // Flattened views used by the bound checker.
  logic [BANKS*DATA_W-1:0] din_all;
  logic [BANKS*DATA_W-1:0] stat_all;
  logic [BANKS*DATA_W-1:0] route_all;

  assign rg_f    = bus_addr[ADDR_W-1:8];
  assign bk_f    = bus_addr[7:4];
  assign op_f    = wr_op_e'(bus_addr[3:2]);
  assign addr_ok = (bus_addr[1:0] == 2'b00);

  always_comb begin
    for (int b = 0; b < BANKS; b++) begin
      for (int r = 0; r < NUM_REGS; r++) begin
        wr_sel[b][r] = bus_wr && addr_ok && (bk_f == BK_W'(b)) && (rg_f == RG_W'(r));
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < BANKS; b++) begin
      for (int r = 0; r < NUM_REGS; r++) begin
        if (addr_ok && (bk_f == BK_W'(b)) && (rg_f == RG_W'(r)))
          rd_mux = bank_regs[b][r*DATA_W +: DATA_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    gpio_bank #(.PINS(int'(PIN_COUNTS[b*8 +: 8]))) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .pad_in    (pad_in[b*DATA_W +: DATA_W]),
      .wr_sel    (wr_sel[b]),
      .op        (op_f),
      .wdata     (bus_wdata),
      .regs_flat (bank_regs[b]),
      .pad_out   (pad_out[b*DATA_W +: DATA_W]),
      .pad_oe    (pad_oe[b*DATA_W +: DATA_W]),
      .irq       (irq[b])
    );
    assign din_all[b*DATA_W +: DATA_W]   = bank_regs[b][int'(RG_INPUT)*DATA_W +: DATA_W];
    assign stat_all[b*DATA_W +: DATA_W]  = bank_regs[b][int'(RG_STAT)*DATA_W +: DATA_W];
    assign route_all[b*DATA_W +: DATA_W] = bank_regs[b][int'(RG_ROUTE)*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/gpio_banked_chk.sv
module gpio_banked_chk
  import gpio_bank_pkg::*;
#(
  parameter int                 BANKS      = 3,
  parameter logic [BANKS*8-1:0] PIN_COUNTS = {8'd21, 8'd32, 8'd29}
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    bus_wr,
  input logic [BANKS*DATA_W-1:0] pad_in,
  input logic [BANKS*DATA_W-1:0] pad_out,
  input logic [BANKS*DATA_W-1:0] pad_oe,
  input logic [BANKS-1:0]        irq,
  input logic [BANKS*DATA_W-1:0] din_all,
  input logic [BANKS*DATA_W-1:0] stat_all,
  input logic [BANKS*DATA_W-1:0] route_all
);
  function automatic logic [BANKS*DATA_W-1:0] all_mask();
    logic [BANKS*DATA_W-1:0] m;
    for (int b = 0; b < BANKS; b++)
      m[b*DATA_W +: DATA_W] = pin_mask(int'(PIN_COUNTS[b*8 +: 8]));
    return m;
  endfunction

  localparam logic [BANKS*DATA_W-1:0] IMPL_ALL = all_mask();

  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  assert_rst_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (irq == '0 && pad_oe == '0 && pad_out == '0));

  assert_absent_pins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe | pad_out | stat_all | din_all) & ~IMPL_ALL) == '0);

  assert_sync_depth_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2) |-> (din_all == ($past(pad_in, 2) & IMPL_ALL)));

  for (genvar b = 0; b < BANKS; b++) begin : g_chk
    assert_route_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(bus_wr) |->
        ((stat_all[b*DATA_W +: DATA_W] & ~$past(stat_all[b*DATA_W +: DATA_W])
          & ~$past(route_all[b*DATA_W +: DATA_W])) == '0));

    assert_irq_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(irq[b]) && !$past(bus_wr)) |-> irq[b]);
  end
endmodule

bind gpio_banked gpio_banked_chk #(.BANKS(BANKS), .PIN_COUNTS(PIN_COUNTS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .pad_in    (pad_in),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe),
  .irq       (irq),
  .din_all   (din_all),
  .stat_all  (stat_all),
  .route_all (route_all)
);

// File: tb/gpio_banked_test.sv
module gpio_banked_test;
  localparam int BANKS = 3;
  localparam int RDRV = 0, RIN = 1, RDIR = 2, RRTE = 3, RIEN = 4, RSTA = 5, RLVL = 6, RPOL = 7;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [11:0]       bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic              bus_wr = 1'b0;
  logic              bus_rd = 1'b0;
  logic [31:0]       bus_rdata;
  logic [BANKS*32-1:0] pad_in = '0;
  logic [BANKS*32-1:0] pad_out;
  logic [BANKS*32-1:0] pad_oe;
  logic [BANKS-1:0]  irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  gpio_banked uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  function automatic logic [11:0] mk(input int rg, input int bk, input int op);
    return 12'(rg * 256 + bk * 16 + op * 4);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int rg, input int bk, input int op, input logic [31:0] d);
    bus_addr = mk(rg, bk, op); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int rg, input int bk, input int op, output logic [31:0] d);
    bus_addr = mk(rg, bk, op); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R13 irq", {29'b0, irq}, 32'h0);
    chk("R13 pad_oe", pad_oe[31:0] | pad_oe[63:32] | pad_oe[95:64], 32'h0);
    rd(RDRV, 1, 0, v); chk("R13 drive reg", v, 32'h0);
    rd(RSTA, 2, 0, v); chk("R13 status reg", v, 32'h0);
  endtask

  task automatic t_ops();
    logic [31:0] v;
    wr(RDRV, 1, 0, 32'hF0F0_00FF); rd(RDRV, 1, 0, v); chk("R2 replace", v, 32'hF0F0_00FF);
    wr(RDRV, 1, 1, 32'h0F00_0000); rd(RDRV, 1, 0, v); chk("R2 set", v, 32'hFFF0_00FF);
    wr(RDRV, 1, 2, 32'h0000_000F); rd(RDRV, 1, 0, v); chk("R2 clear", v, 32'hFFF0_00F0);
    wr(RDRV, 1, 3, 32'h0000_FFFF); rd(RDRV, 1, 0, v); chk("R2 toggle", v, 32'hFFF0_FF0F);
    rd(RDRV, 1, 3, v); chk("R3 alias read", v, 32'hFFF0_FF0F);
    rd(9, 1, 0, v); chk("R3 bad register", v, 32'h0);
    rd(RDRV, 5, 0, v); chk("R3 bad bank", v, 32'h0);
  endtask

  task automatic t_banks_dir();
    logic [31:0] v;
    wr(RDIR, 2, 0, 32'h0000_1234);
    rd(RDIR, 2, 0, v); chk("R1 bank2 dir", v, 32'h0000_1234);
    rd(RDIR, 0, 0, v); chk("R1 bank0 untouched", v, 32'h0);
    chk("R4 pad_oe bank2", pad_oe[95:64], 32'h0000_1234);
    wr(RDIR, 1, 0, 32'hFFFF_0000);
    chk("R4 pad_oe bank1", pad_oe[63:32], 32'hFFFF_0000);
    chk("R4 pad_out bank1", pad_out[63:32], 32'hFFF0_FF0F);
  endtask

  task automatic t_absent();
    logic [31:0] v;
    wr(RDRV, 0, 0, 32'hFFFF_FFFF); rd(RDRV, 0, 0, v); chk("R12 bank0 29 pins", v, 32'h1FFF_FFFF);
    chk("R12 pad_out bank0", pad_out[31:0], 32'h1FFF_FFFF);
    wr(RDRV, 2, 1, 32'hFFFF_FFFF); rd(RDRV, 2, 0, v); chk("R12 bank2 21 pins", v, 32'h001F_FFFF);
  endtask

  task automatic t_input();
    logic [31:0] v;
    pad_in[63:32] = 32'hA5A5_5A5A;
    idle(1);
    rd(RIN, 1, 0, v); chk("R5 one edge old", v, 32'h0);
    rd(RIN, 1, 0, v); chk("R5 two edges new", v, 32'hA5A5_5A5A);
    wr(RIN, 1, 1, 32'hFFFF_FFFF); wr(RIN, 1, 0, 32'h0);
    rd(RIN, 1, 0, v); chk("R5 writes ignored", v, 32'hA5A5_5A5A);
    wr(RDIR, 1, 0, 32'hFFFF_FFFF);
    rd(RIN, 1, 2, v); chk("R5 output pins read", v, 32'hA5A5_5A5A);
    pad_in[31:0] = 32'hE000_0001; idle(3);
    rd(RIN, 0, 0, v); chk("R12 absent input", v, 32'h0000_0001);
  endtask

  task automatic t_edge();
    logic [31:0] v;
    wr(RPOL, 0, 1, 32'h8); wr(RRTE, 0, 1, 32'h8); wr(RIEN, 0, 1, 32'h8);
    pad_in[3] = 1'b1; idle(4);
    chk("R7 rise irq", {31'b0, irq[0]}, 32'h1);
    rd(RSTA, 0, 0, v); chk("R7 rise status", v, 32'h8);
    pad_in[3] = 1'b0; idle(4);
    rd(RSTA, 0, 0, v); chk("R7 sticky", v, 32'h8);
    wr(RSTA, 0, 2, 32'h8);
    rd(RSTA, 0, 0, v); chk("R11 clear bit", v, 32'h0);
    chk("R10 irq drops", {31'b0, irq[0]}, 32'h0);
    wr(RPOL, 0, 2, 32'h8);
    pad_in[3] = 1'b1; idle(4);
    rd(RSTA, 0, 0, v); chk("R6 code0 ignores rise", v, 32'h0);
    pad_in[3] = 1'b0; idle(4);
    rd(RSTA, 0, 0, v); chk("R6 code0 falls", v, 32'h8);
  endtask

  task automatic t_level();
    logic [31:0] v;
    pad_in[63:32] = 32'hFFFF_FFFF; idle(3);
    wr(RLVL, 1, 1, 32'h1); wr(RRTE, 1, 1, 32'h1); wr(RIEN, 1, 1, 32'h1);
    chk("R6 code1 idle high", {31'b0, irq[1]}, 32'h0);
    pad_in[32] = 1'b0; idle(4);
    chk("R8 low level irq", {31'b0, irq[1]}, 32'h1);
    wr(RSTA, 1, 2, 32'h1);
    chk("R8 cleared one cycle", {31'b0, irq[1]}, 32'h0);
    idle(1);
    chk("R8 reasserts", {31'b0, irq[1]}, 32'h1);
    pad_in[32] = 1'b1; idle(4);
    wr(RSTA, 1, 2, 32'hFFFF_FFFF); idle(3);
    chk("R8 level gone", {31'b0, irq[1]}, 32'h0);
    rd(RSTA, 1, 0, v); chk("R8 status clear", v, 32'h0);
  endtask

  task automatic t_route_enable();
    logic [31:0] v;
    wr(RPOL, 2, 1, 32'h20); wr(RIEN, 2, 1, 32'h20);
    pad_in[69] = 1'b1; idle(4);
    rd(RSTA, 2, 0, v); chk("R9 unrouted quiet", v, 32'h0);
    chk("R9 irq quiet", {31'b0, irq[2]}, 32'h0);
    pad_in[69] = 1'b0; idle(3);
    wr(RRTE, 2, 1, 32'h20); wr(RIEN, 2, 2, 32'h20);
    pad_in[69] = 1'b1; idle(4);
    rd(RSTA, 2, 0, v); chk("R10 recorded while masked", v, 32'h20);
    chk("R10 masked irq", {31'b0, irq[2]}, 32'h0);
    wr(RIEN, 2, 1, 32'h20);
    chk("R10 unmasked irq", {31'b0, irq[2]}, 32'h1);
    wr(RSTA, 2, 2, 32'hFFFF_FFFF);
  endtask

  task automatic t_clear_race();
    logic [31:0] v;
    wr(RPOL, 0, 1, 32'h10); wr(RRTE, 0, 1, 32'h10); wr(RIEN, 0, 1, 32'h10);
    pad_in[4] = 1'b1;
    @(negedge clk); @(negedge clk);
    wr(RSTA, 0, 2, 32'hFFFF_FFFF);
    idle(2);
    rd(RSTA, 0, 0, v); chk("R11 edge survives clear-all", v, 32'h10);
    wr(RSTA, 0, 2, 32'hFFFF_FFFF);
    rd(RSTA, 0, 0, v); chk("R11 clear-all", v, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_ops();
    t_banks_dir();
    t_absent();
    t_input();
    t_edge();
    t_level();
    t_route_enable();
    t_clear_race();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule